// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives CAN bit timing from the system clock. A prescaler divides the clock into time quanta. Each bit has three parts, in this order: one synchronisation quantum, a first timing segment (propagation plus the first phase segment), and a second phase segment. At the end of the first segment the block raises a one-cycle sample strobe. At the end of the second segment it raises a transmit-point strobe, which marks the bit boundary where a transmitter may change the line.

The receive line passes through a two-stage register. A recessive-to-dominant transition on it resynchronises the bit in one of two ways:

- While the start-of-frame arm input is high, the transition causes a hard sync, which restarts the bit at the synchronisation quantum.
- Otherwise it adjusts the current bit. The first segment is lengthened, or the second is shortened, by at most the jump width.

The sampled bit comes either from a single sample or, when the block is configured for it, from a two-of-three majority vote.

All timing comes from one packed 24-bit configuration word. Each field in the word holds its value minus one. The word is accepted only while the configuration-enable input is high, and bit timing is frozen for as long as that input stays high.

Top module: `can_bit_timer`

## Requirements
- R1: A time quantum lasts P clocks. P is configuration bits 23:16 plus one, giving 1 to 256.
- R2: A bit lasts 1+T1+T2 quanta. T1 is bits 6:3 plus one (1 to 16) and T2 is bits 2:0 plus one (1 to 8). `sample_stb` pulses for one clock at the end of the last T1 quantum. `txpt_stb` pulses at the end of the last T2 quantum, so a transmit point is followed (1+T1)·P clocks later by a sample strobe. The two strobes never coincide.
- R3: The configuration word loads from `cfg_wdata` on a clock where both `cfg_we` and `cfg_en` are high. A write while `cfg_en` is low has no effect.
- R4: While `cfg_en` is high, neither strobe pulses. The bit restarts at the synchronisation quantum when `cfg_en` falls.
- R5: While `sof_arm` is high, a 1-to-0 transition of `rx_in` forces a hard sync. The new bit begins two clocks after `rx_in` is first seen low, and its sample strobe falls 1+(1+T1)·P clocks after that first low clock edge.
- R6: A falling edge with `sof_arm` low, seen in quantum c of the first segment (c counted from 0), lengthens that segment by min(c+1, SJW) quanta. SJW is bits 9:8 plus one (1 to 4). The prescaler keeps running.
- R7: A falling edge with `sof_arm` low, seen in the second segment with r quanta remaining (r counted including the current quantum), works as follows. If r ≤ SJW, the bit restarts at the synchronisation quantum and the prescaler restarts. Otherwise the segment is shortened by SJW quanta.
- R8: Rising edges of `rx_in` have no effect on timing. An edge in the synchronisation quantum has no effect. At most one resync is applied per bit.
- R9: In single-sample mode, `rx_bit` takes the registered receive value at the sample strobe and changes only on the clock after a strobe.
- R10: When bit 7 is set and P > 4, `rx_bit` is the majority of the registered receive values at the last three quantum ends of the first segment. When bit 7 is set and P ≤ 4, single sampling applies.
- R11: After reset the configuration word is zero, which means P=1, T1=1, T2=1 and a 3-clock bit, and `rx_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration mode: allows writes and freezes timing |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Packed timing word |
| sof_arm | input | 1 | Next falling edge is a hard sync |
| rx_in | input | 1 | Receive line (1 = recessive) |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| txpt_stb | output | 1 | One-clock pulse at the bit boundary |
| rx_bit | output | 1 | Sampled bit value |

## Verification
The bench builds the block with the package's default field widths: an 8-bit prescaler field, a 4-bit first segment, a 3-bit second segment and a 2-bit jump width. These widths bring the full 256-clock quantum and the four-quantum jump limit within reach, and the bench exercises the largest prescaler setting. Edges are placed relative to a hard sync so that they land in chosen quanta. This covers lengthening below and at the jump limit, shortening above the limit, and restart when the remaining quanta fit within it. The triple-sampling tests use a one-quantum glitch placed just before the sample point, at prescalers of 5 and 4, on either side of the threshold.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    // Field widths of the packed timing word (each field holds value - 1)
    localparam int PRESC_FW = 8;
    localparam int TS1_FW   = 4;
    localparam int TS2_FW   = 3;
    localparam int SJW_FW   = 2;

    // Field positions: these are decoded by software writing the word
    localparam int TS2_LSB    = 0;
    localparam int TS1_LSB    = TS2_LSB + TS2_FW;
    localparam int TRIPLE_BIT = TS1_LSB + TS1_FW;
    localparam int SJW_LSB    = 8;
    localparam int PRESC_LSB  = 16;
    localparam int REG_W      = PRESC_LSB + PRESC_FW;

    // Widths of decoded (value, not value-1) fields
    localparam int PRESC_VW = PRESC_FW + 1;
    localparam int TS1_VW   = TS1_FW + 1;
    localparam int TS2_VW   = TS2_FW + 1;
    localparam int SJW_VW   = SJW_FW + 1;

    // Segment counter must hold TS1 max plus SJW max
    localparam int CNT_W = TS1_VW + 1;

    // Smallest prescaler at which majority sampling is honoured
    localparam int TRIPLE_MIN_PRESC = 5;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [PRESC_VW-1:0] presc;
        logic [TS1_VW-1:0]   ts1;
        logic [TS2_VW-1:0]   ts2;
        logic [SJW_VW-1:0]   sjw;
        logic                triple;
    } bt_cfg_t;

    function automatic bt_cfg_t decode_timing(input logic [REG_W-1:0] raw);
        bt_cfg_t c;
        c.presc  = PRESC_VW'(raw[PRESC_LSB +: PRESC_FW]) + PRESC_VW'(1);
        c.ts1    = TS1_VW'(raw[TS1_LSB +: TS1_FW]) + TS1_VW'(1);
        c.ts2    = TS2_VW'(raw[TS2_LSB +: TS2_FW]) + TS2_VW'(1);
        c.sjw    = SJW_VW'(raw[SJW_LSB +: SJW_FW]) + SJW_VW'(1);
        c.triple = raw[TRIPLE_BIT] && (c.presc >= PRESC_VW'(TRIPLE_MIN_PRESC));
        return c;
    endfunction

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
#(
    parameter int VW = PRESC_VW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          restart,
    input  logic [VW-1:0] div,
    output logic          tick
);

    logic [VW-1:0] cnt;

    assign tick = !hold && (cnt == div - VW'(1));

    always_ff @(posedge clk) begin
        if (rst || hold || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + VW'(1);
        end
    end

    // R1: with a divide above one, quantum ends are never back to back
    p_quantum_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && div > VW'(1)) |=> !tick);

    // R1: the divider count stays inside the quantum
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        !hold |-> cnt < div);

endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    input  logic sof_arm,
    output logic rx_s,
    output logic hard_edge,
    output logic resync_edge
);

    logic rx_d;
    logic falling;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s <= 1'b1;
            rx_d <= 1'b1;
        end else begin
            rx_s <= rx_in;
            rx_d <= rx_s;
        end
    end

    assign falling     = rx_d && !rx_s;
    assign hard_edge   = falling && sof_arm;
    assign resync_edge = falling && !sof_arm;

endmodule

// File: rtl/can_bt_seg_fsm.sv
module can_bt_seg_fsm
    import can_bt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              tick,
    input  logic              hard_edge,
    input  logic              resync_edge,
    input  logic [TS1_VW-1:0] ts1,
    input  logic [TS2_VW-1:0] ts2,
    input  logic [SJW_VW-1:0] sjw,
    output logic              sample_stb,
    output logic              txpt_stb,
    output logic              presc_restart
);

    seg_e             seg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ph1_lim;
    logic [CNT_W-1:0] ph2_lim;
    logic             resynced;

    logic [CNT_W-1:0] sjw_c;
    logic [CNT_W-1:0] late_err;
    logic [CNT_W-1:0] late_ext;
    logic [CNT_W-1:0] remain;
    logic             do_late;
    logic             do_early;
    logic             early_restart;
    logic             early_short;
    logic [CNT_W-1:0] lim1_eff;
    logic [CNT_W-1:0] lim2_eff;
    logic             restart_bit;

    always_comb begin
        sjw_c         = CNT_W'(sjw);
        late_err      = cnt + CNT_W'(1);
        late_ext      = (late_err < sjw_c) ? late_err : sjw_c;
        remain        = ph2_lim - cnt;
        do_late       = resync_edge && !resynced && (seg == SEG_PH1);
        do_early      = resync_edge && !resynced && (seg == SEG_PH2);
        early_restart = do_early && (remain <= sjw_c);
        early_short   = do_early && !early_restart;
        lim1_eff      = ph1_lim + (do_late ? late_ext : '0);
        lim2_eff      = ph2_lim - (early_short ? sjw_c : '0);
        restart_bit   = hard_edge || early_restart;
    end

    assign sample_stb    = tick && (seg == SEG_PH1) && (cnt == lim1_eff - CNT_W'(1))
                           && !hard_edge;
    assign txpt_stb      = tick && (seg == SEG_PH2) && (cnt >= lim2_eff - CNT_W'(1))
                           && !restart_bit;
    assign presc_restart = restart_bit;

    always_ff @(posedge clk) begin
        if (rst || hold || restart_bit) begin
            seg      <= SEG_SYNC;
            cnt      <= '0;
            ph1_lim  <= CNT_W'(ts1);
            ph2_lim  <= CNT_W'(ts2);
            resynced <= 1'b0;
        end else begin
            if (do_late) begin
                ph1_lim  <= lim1_eff;
                resynced <= 1'b1;
            end
            if (early_short) begin
                ph2_lim  <= lim2_eff;
                resynced <= 1'b1;
            end
            if (tick) begin
                unique case (seg)
                    SEG_SYNC: begin
                        seg <= SEG_PH1;
                        cnt <= '0;
                    end
                    SEG_PH1: begin
                        if (cnt == lim1_eff - CNT_W'(1)) begin
                            seg <= SEG_PH2;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    SEG_PH2: begin
                        if (cnt >= lim2_eff - CNT_W'(1)) begin
                            seg      <= SEG_SYNC;
                            cnt      <= '0;
                            ph1_lim  <= CNT_W'(ts1);
                            ph2_lim  <= CNT_W'(ts2);
                            resynced <= 1'b0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: seg <= SEG_SYNC;
                endcase
            end
        end
    end

    // R6: first segment count never passes its (possibly lengthened) limit
    p_ph1_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_PH1) |-> cnt < ph1_lim);

    // R7: second segment count never passes its (possibly shortened) limit
    p_ph2_bound_r7: assert property (@(posedge clk) disable iff (rst)
        (seg == SEG_PH2) |-> cnt < ph2_lim);

    // R5: a hard sync lands in the first quantum of a new bit
    p_hard_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (hard_edge && !hold) |=> (seg == SEG_SYNC && cnt == '0));

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
    import can_bt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sample_stb,
    input  logic triple,
    input  logic rx_s,
    output logic rx_bit
);

    logic [1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= 2'b11;
            rx_bit <= 1'b1;
        end else begin
            if (tick) begin
                hist <= {hist[0], rx_s};
            end
            if (sample_stb) begin
                rx_bit <= triple ? vote3(hist[1], hist[0], rx_s) : rx_s;
            end
        end
    end

    // R9: the sampled bit moves only on the clock after a sample strobe
    p_rxbit_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(rx_bit));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             sof_arm,
    input  logic             rx_in,
    output logic             sample_stb,
    output logic             txpt_stb,
    output logic             rx_bit
);

    logic [REG_W-1:0] cfg_raw;
    bt_cfg_t          cfg;
    logic             tick;
    logic             rx_s;
    logic             hard_edge;
    logic             resync_edge;
    logic             presc_restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_raw <= '0;
        end else if (cfg_we && cfg_en) begin
            cfg_raw <= cfg_wdata;
        end
    end

    assign cfg = decode_timing(cfg_raw);

    can_bt_prescaler #(.VW(PRESC_VW)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .hold    (cfg_en),
        .restart (presc_restart),
        .div     (cfg.presc),
        .tick    (tick)
    );

    can_bt_edge u_edge (
        .clk         (clk),
        .rst         (rst),
        .rx_in       (rx_in),
        .sof_arm     (sof_arm),
        .rx_s        (rx_s),
        .hard_edge   (hard_edge),
        .resync_edge (resync_edge)
    );

    can_bt_seg_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .hold          (cfg_en),
        .tick          (tick),
        .hard_edge     (hard_edge),
        .resync_edge   (resync_edge),
        .ts1           (cfg.ts1),
        .ts2           (cfg.ts2),
        .sjw           (cfg.sjw),
        .sample_stb    (sample_stb),
        .txpt_stb      (txpt_stb),
        .presc_restart (presc_restart)
    );

    can_bt_sampler u_samp (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .sample_stb (sample_stb),
        .triple     (cfg.triple),
        .rx_s       (rx_s),
        .rx_bit     (rx_bit)
    );

    // R3: the timing word is untouched unless written in configuration mode
    p_cfg_locked_r3: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_en) |=> $stable(cfg_raw));

    // R4: no strobes while in configuration mode
    p_quiet_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (!sample_stb && !txpt_stb));

    // R2: sample point and bit boundary never coincide
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_stb, txpt_stb}));

endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int WAIT_LIMIT = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        sof_arm = 1'b0;
    logic        rx_in = 1'b1;
    logic        sample_stb;
    logic        txpt_stb;
    logic        rx_bit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timer uut (
        .clk        (clk),
        .rst        (rst),
        .cfg_en     (cfg_en),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .sof_arm    (sof_arm),
        .rx_in      (rx_in),
        .sample_stb (sample_stb),
        .txpt_stb   (txpt_stb),
        .rx_bit     (rx_bit)
    );

    function automatic logic [23:0] pack(int brp, int t1, int t2, int sjw, bit sam);
        logic [23:0] w;
        w        = '0;
        w[23:16] = 8'(brp - 1);
        w[9:8]   = 2'(sjw - 1);
        w[7]     = sam;
        w[6:3]   = 4'(t1 - 1);
        w[2:0]   = 3'(t2 - 1);
        return w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts rising edges until the chosen strobe is seen at a falling edge
    task automatic count_to(input bit use_txpt, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if ((use_txpt ? txpt_stb : sample_stb) === 1'b1) break;
            if (n > WAIT_LIMIT) break;
        end
    endtask

    task automatic interval(input bit use_txpt, output int n);
        int dummy;
        count_to(use_txpt, dummy);
        count_to(use_txpt, n);
    endtask

    task automatic write_cfg(input logic [23:0] w, input bit en);
        @(posedge clk); #1;
        cfg_en = en; cfg_we = 1'b1; cfg_wdata = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        repeat (2) @(posedge clk);
        #1 cfg_en = 1'b0;
    endtask

    // Idle the line, arm, then drive the start-of-frame edge just after a clock edge
    task automatic hard_sync();
        @(posedge clk); #1;
        rx_in = 1'b1; sof_arm = 1'b1;
        repeat (4) @(posedge clk);
        #1 rx_in = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        check("R11 rx_bit after reset", int'(rx_bit), 1);
        interval(1'b0, n);
        check("R11 default bit length", n, 3);
    endtask

    task automatic t_prescale();
        int n;
        write_cfg(pack(1, 1, 1, 1, 0), 1'b1);
        interval(1'b0, n);
        check("R1 prescale 1 bit length", n, 3);
        write_cfg(pack(3, 2, 1, 1, 0), 1'b1);
        interval(1'b0, n);
        check("R1 prescale 3 bit length", n, 12);
        interval(1'b1, n);
        check("R2 transmit point period", n, 12);
        count_to(1'b1, n);
        count_to(1'b0, n);
        check("R2 transmit point to sample", n, 9);
        write_cfg(pack(256, 1, 1, 1, 0), 1'b1);
        interval(1'b0, n);
        check("R1 prescale 256 bit length", n, 768);
        write_cfg(pack(2, 16, 8, 4, 0), 1'b1);
        interval(1'b0, n);
        check("R2 max segments bit length", n, 50);
    endtask

    task automatic t_cfg_lock();
        int n;
        write_cfg(pack(2, 3, 2, 1, 0), 1'b1);
        interval(1'b0, n);
        check("R3 accepted write", n, 12);
        write_cfg(pack(4, 5, 5, 1, 0), 1'b0);
        interval(1'b0, n);
        check("R3 write ignored outside config mode", n, 12);
    endtask

    task automatic t_hold();
        int seen;
        seen = 0;
        @(posedge clk); #1 cfg_en = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (sample_stb || txpt_stb) seen++;
        end
        @(posedge clk); #1 cfg_en = 1'b0;
        check("R4 strobes while in config mode", seen, 0);
    endtask

    // Config used by the resync tests: P=2 T1=6 T2=4 SJW=2, bit = 22 clocks
    localparam int RP = 2, RT1 = 6, RT2 = 4, RSJ = 2;
    localparam int RL = (1 + RT1 + RT2) * RP;

    task automatic t_hard();
        int n;
        write_cfg(pack(RP, RT1, RT2, RSJ, 0), 1'b1);
        hard_sync();
        count_to(1'b0, n);
        check("R5 hard sync to sample", n, 1 + (1 + RT1) * RP);
        @(negedge clk);
        check("R9 single sample dominant", int'(rx_bit), 0);
        repeat (7) @(posedge clk);
        hard_sync();
        count_to(1'b0, n);
        check("R5 second hard sync to sample", n, 1 + (1 + RT1) * RP);
    endtask

    // Falling edge in first segment quantum c of the bit after the hard sync
    task automatic t_late(input int c, input int exp, input string req);
        int n;
        hard_sync();
        repeat (3) @(posedge clk);
        #1 begin sof_arm = 1'b0; rx_in = 1'b1; end
        repeat (1 + RL + RP * (1 + c) - 3) @(posedge clk);
        #1 rx_in = 1'b0;
        count_to(1'b0, n);
        check(req, n, exp);
    endtask

    // Falling edge in second segment quantum j of the bit after the hard sync
    task automatic t_early(input int j, input int exp, input string req);
        int n;
        hard_sync();
        repeat (3) @(posedge clk);
        #1 begin sof_arm = 1'b0; rx_in = 1'b1; end
        repeat (1 + RL + RP * (1 + RT1 + j) - 3) @(posedge clk);
        #1 rx_in = 1'b0;
        count_to(1'b0, n);
        check(req, n, exp);
    endtask

    task automatic t_rise();
        int n;
        hard_sync();
        repeat (3) @(posedge clk);
        #1 sof_arm = 1'b0;
        repeat (1 + RL + RP * (1 + 3) - 3) @(posedge clk);
        #1 rx_in = 1'b1;
        count_to(1'b0, n);
        check("R8 rising edge leaves timing", n, (RT1 - 3) * RP);
    endtask

    task automatic t_once();
        int n;
        hard_sync();
        repeat (3) @(posedge clk);
        #1 begin sof_arm = 1'b0; rx_in = 1'b1; end
        repeat (1 + RL + RP - 3) @(posedge clk);
        #1 rx_in = 1'b0;
        repeat (2) @(posedge clk);
        #1 rx_in = 1'b1;
        repeat (2) @(posedge clk);
        #1 rx_in = 1'b0;
        count_to(1'b0, n);
        check("R8 second edge in same bit ignored", n, (RT1 + 1) * RP - 4);
    endtask

    // One-quantum recessive glitch ending at the sample point
    task automatic t_glitch(input int brp, input bit sam, input int exp, input string req);
        int n;
        write_cfg(pack(brp, 4, 2, 1, sam), 1'b1);
        hard_sync();
        repeat (3) @(posedge clk);
        #1 sof_arm = 1'b0;
        repeat ((4 + 1) * brp - 2 - 3) @(posedge clk);
        #1 rx_in = 1'b1;
        count_to(1'b0, n);
        @(posedge clk);
        @(negedge clk);
        check(req, int'(rx_bit), exp);
        #1 rx_in = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_cfg_lock();
        t_hold();
        t_hard();
        t_late(0, (RT1 + 1 - 0) * RP, "R6 late edge short error");
        t_late(3, (RT1 + RSJ - 3) * RP, "R6 late edge clipped to jump width");
        t_early(0, RL - (RSJ + 0) * RP, "R7 early edge shortens by jump width");
        t_early(1, RL - (RSJ + 1) * RP, "R7 early edge shortens at j=1");
        t_early(2, 1 + (1 + RT1) * RP, "R7 early edge restarts bit");
        t_rise();
        t_once();
        t_glitch(5, 1'b1, 0, "R10 majority rejects glitch");
        t_glitch(5, 1'b0, 1, "R9 single sample takes glitch");
        t_glitch(4, 1'b1, 1, "R10 majority refused at prescale 4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule